// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Coherent Compare Loading

This block is a single channel of a free-running timer. The counter lives outside the block and arrives on an input, along with a tick enable that marks each timer clock. Software reaches the channel through a narrow byte-wide register bus. The bus carries one control/status register and the channel value, which is split into byte-sized pieces.

The channel has two working modes. In output-compare mode, software loads a target count. When the counter reaches that target, the channel raises its flag and drives its output pin as the control register selects: leave it, toggle it, clear it or set it. Byte writes to the target do not go straight into the active comparator. They collect in a holding buffer, and the whole value moves across in one step only once every byte has arrived, whatever order the bytes came in. Any write to the control register throws away a partly filled buffer. In input-capture mode, the channel samples the counter into its value register on the selected edge of an input pin and raises the flag. An interrupt line follows the flag, gated by an enable bit.

Top module: `tcc_channel`

## Requirements
- R1: After synchronous reset, the control register, the channel value, pin_out and irq all read 0.
- R2: In output-compare mode (mode field 2'b10), a byte written to the value goes into a holding buffer. The value read back at addresses 1 and 2 does not change while only part of the bytes have been received.
- R3: Once both bytes are received, in either order, the buffer moves to the active value on the first clock edge with tick high that follows the edge which stored the second byte. A control write on that same edge cancels the transfer.
- R4: A write to the control register (address 0) discards the received-byte tracking. A byte written before that write never reaches the active value; after it, both bytes must be written again.
- R5: In output-compare mode, an edge with tick high and cnt_in equal to the active value sets the flag. The same edge applies the pin action held in control bits 3:2: 00 leaves pin_out, 01 toggles it, 10 clears it, 11 sets it.
- R6: In input-capture mode (mode 2'b01), pin_in is sampled on every clock. A rising edge is 1 now after 0 at the previous edge; a falling edge is the reverse. Control bits 3:2 select the edge: 01 rising, 10 falling, 11 either, 00 none. On a selected edge the value register takes cnt_in and the flag sets.
- R7: irq is high exactly while the flag (control bit 7) and the interrupt enable (control bit 6) are both 1.
- R8: A read of address 0 with the flag set arms a clear. The next control write with bit 7 at 0 then clears the flag. A control write without that prior armed read leaves the flag set. A flag-setting event on the same edge wins over a clear.
- R9: Outside output-compare mode, a byte written to address 1 or 2 lands directly in the value register on that clock edge.
- R10: Address 0 reads {flag, enable, mode[1:0], select[1:0], 2'b00}, with bits 1:0 always read as 0. Address 1 reads the high value byte, address 2 reads the low byte, and address 3 reads 0. Mode 2'b00 and mode 2'b11 are both idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; the counter advances on edges where it is high |
| cnt_in | input | 16 | Free-running counter value |
| pin_in | input | 1 | Capture input pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach: a half-written target that a control write cuts off, and a finished target that sits waiting while tick stays low. The stimulus writes one byte, writes the control register, and then writes only the other byte. It reads the value back to show that the old target survives and that no match fires at the abandoned count. It then slows tick to one edge in six and stores both bytes. The per-clock reference model then pins down the exact edge where the read-back value changes.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'b00,
        MD_CAPT = 2'b01,
        MD_CMP  = 2'b10,
        MD_RSV  = 2'b11
    } mode_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        mode_e      mode;
        logic [1:0] sel;
    } ctrl_t;

    localparam logic [1:0] ACT_KEEP   = 2'b00;
    localparam logic [1:0] ACT_TOGGLE = 2'b01;
    localparam logic [1:0] ACT_CLEAR  = 2'b10;
    localparam logic [1:0] ACT_SET    = 2'b11;

    function automatic logic pin_next(logic [1:0] act, logic cur);
        case (act)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

    function automatic logic edge_hit(logic [1:0] sel, logic rise, logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

    function automatic logic [7:0] ctrl_pack(ctrl_t c);
        return {c.flag, c.ie, c.mode, c.sel, 2'b00};
    endfunction

endpackage

// File: rtl/tcc_edge.sv
module tcc_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_in;
    end

    assign rise = pin_in & ~pin_q;
    assign fall = ~pin_in & pin_q;
endmodule

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:2] wdata,
    input  logic       set_evt,
    output ctrl_t      ctl,
    output logic       arm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{flag: 1'b0, ie: 1'b0, mode: MD_IDLE, sel: 2'b00};
            arm <= 1'b0;
        end else begin
            if (wr) begin
                ctl.ie   <= wdata[6];
                ctl.mode <= mode_e'(wdata[5:4]);
                ctl.sel  <= wdata[3:2];
                arm      <= 1'b0;
            end else if (rd && ctl.flag) begin
                arm <= 1'b1;
            end
            if (set_evt)                      ctl.flag <= 1'b1;
            else if (wr && arm && !wdata[7])  ctl.flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tcc_valbuf.sv
module tcc_valbuf #(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8,
    localparam int NB    = CNT_W / BUS_W,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oc_mode,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             val_wr,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [BUS_W-1:0] wdata,
    input  logic             capt_evt,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] act,
    output logic [CNT_W-1:0] hold,
    output logic [NB-1:0]    got,
    output logic             commit
);
    assign commit = oc_mode & (&got) & tick & ~ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            hold <= '0;
            got  <= '0;
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (val_wr && byte_idx == IDX_W'(k))
                    hold[CNT_W-1-k*BUS_W -: BUS_W] <= wdata;
                if (ctrl_wr)
                    got[k] <= 1'b0;
                else
                    got[k] <= (got[k] & ~commit) |
                              (val_wr & oc_mode & (byte_idx == IDX_W'(k)));
            end
            if (capt_evt) begin
                act <= cnt_in;
            end else if (commit) begin
                act <= hold;
            end else if (val_wr && !oc_mode) begin
                for (int k = 0; k < NB; k++)
                    if (byte_idx == IDX_W'(k))
                        act[CNT_W-1-k*BUS_W -: BUS_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8,
    localparam int NB    = CNT_W / BUS_W,
    localparam int AW    = $clog2(NB + 1),
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             pin_in,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             pin_out,
    output logic             irq
);
    ctrl_t            ctl;
    logic             arm;
    logic             ctrl_wr, ctrl_rd, val_wr;
    logic [IDX_W-1:0] byte_idx;
    logic             oc_mode, capt_mode;
    logic             rise, fall;
    logic             match, capt_evt, set_evt;
    logic [CNT_W-1:0] act, hold;
    logic [NB-1:0]    got;
    logic             commit;
    logic             pin_q;
    logic             flag_w;

    assign ctrl_wr   = bus_wr && (bus_addr == '0);
    assign ctrl_rd   = bus_rd && (bus_addr == '0);
    assign val_wr    = bus_wr && (bus_addr != '0) && (bus_addr <= AW'(NB));
    assign byte_idx  = IDX_W'(bus_addr - AW'(1));
    assign oc_mode   = (ctl.mode == MD_CMP);
    assign capt_mode = (ctl.mode == MD_CAPT);
    assign match     = oc_mode & tick & (cnt_in == act);
    assign capt_evt  = capt_mode & edge_hit(ctl.sel, rise, fall);
    assign set_evt   = match | capt_evt;
    assign flag_w    = ctl.flag;

    tcc_edge edge_i (
        .clk   (clk),
        .rst   (rst),
        .pin_in(pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    tcc_ctrl ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctrl_wr),
        .rd     (ctrl_rd),
        .wdata  (bus_wdata[7:2]),
        .set_evt(set_evt),
        .ctl    (ctl),
        .arm    (arm)
    );

    tcc_valbuf #(.CNT_W(CNT_W), .BUS_W(BUS_W)) valbuf_i (
        .clk     (clk),
        .rst     (rst),
        .oc_mode (oc_mode),
        .tick    (tick),
        .ctrl_wr (ctrl_wr),
        .val_wr  (val_wr),
        .byte_idx(byte_idx),
        .wdata   (bus_wdata),
        .capt_evt(capt_evt),
        .cnt_in  (cnt_in),
        .act     (act),
        .hold    (hold),
        .got     (got),
        .commit  (commit)
    );

    always_ff @(posedge clk) begin
        if (rst)        pin_q <= 1'b0;
        else if (match) pin_q <= pin_next(ctl.sel, pin_q);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata = BUS_W'(ctrl_pack(ctl));
        for (int k = 0; k < NB; k++)
            if (bus_addr == AW'(k + 1))
                bus_rdata = act[CNT_W-1-k*BUS_W -: BUS_W];
    end

    assign pin_out = pin_q;
    assign irq     = ctl.flag & ctl.ie;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8,
    localparam int NB   = CNT_W / BUS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             oc_mode,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_in,
    input logic [CNT_W-1:0] act,
    input logic [CNT_W-1:0] hold,
    input logic [NB-1:0]    got,
    input logic             ctrl_wr,
    input logic             capt_evt,
    input logic             arm,
    input logic             flag
);
    AST_PARTIAL_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (oc_mode && !(&got)) |=> $stable(act)); // R2

    AST_FULL_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (oc_mode && (&got) && tick && !ctrl_wr && !capt_evt) |=> (act == $past(hold))); // R3

    AST_CTRL_WR_DROPS_BYTES: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (got == '0)); // R4

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (oc_mode && tick && cnt_in == act) |=> flag); // R5

    AST_CAPTURE_LATCHES_CNT: assert property (@(posedge clk) disable iff (rst)
        capt_evt |=> (act == $past(cnt_in) && flag)); // R6

    AST_UNARMED_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !arm && flag) |=> flag); // R8
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .oc_mode (oc_mode),
    .tick    (tick),
    .cnt_in  (cnt_in),
    .act     (act),
    .hold    (hold),
    .got     (got),
    .ctrl_wr (ctrl_wr),
    .capt_evt(capt_evt),
    .arm     (arm),
    .flag    (flag_w)
);

// File: tb/tcc_channel_tb_top.sv
module tcc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [15:0] cnt;
    logic        pin_in = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        pin_out, irq;

    int    total = 0, bad = 0;
    int    tick_div = 1, ph = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tcc_channel dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cnt_in(cnt), .pin_in(pin_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) cnt <= 16'd0;
        else if (tick) cnt <= cnt + 16'd1;
    end

    // behavioural reference model
    logic        m_flag, m_ie, m_arm, m_pin, m_pinq, m_ghi, m_glo;
    logic [1:0]  m_mode, m_sel;
    logic [15:0] m_val;
    logic [7:0]  m_hhi, m_hlo;
    logic        t_oc, t_cap, t_hit, t_cwr, t_crd, t_vwr, t_cmt, t_rise, t_fall;

    always @(posedge clk) begin
        if (rst) begin
            m_flag = 0; m_ie = 0; m_arm = 0; m_pin = 0; m_pinq = 0;
            m_ghi = 0; m_glo = 0; m_mode = 0; m_sel = 0;
            m_val = 0; m_hhi = 0; m_hlo = 0;
        end else begin
            t_oc   = (m_mode == 2'b10);
            t_rise = pin_in && !m_pinq;
            t_fall = !pin_in && m_pinq;
            t_cap  = (m_mode == 2'b01) && ((m_sel[0] && t_rise) || (m_sel[1] && t_fall));
            t_cwr  = bus_wr && bus_addr == 2'd0;
            t_crd  = bus_rd && bus_addr == 2'd0;
            t_vwr  = bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2);
            t_hit  = t_oc && tick && cnt == m_val;
            t_cmt  = t_oc && m_ghi && m_glo && tick && !t_cwr;
            if (t_cap) m_val = cnt;
            else if (t_cmt) m_val = {m_hhi, m_hlo};
            else if (t_vwr && !t_oc) begin
                if (bus_addr == 2'd1) m_val[15:8] = bus_wdata;
                else                  m_val[7:0]  = bus_wdata;
            end
            if (t_hit) begin
                if (m_sel == 2'b01) m_pin = !m_pin;
                else if (m_sel == 2'b10) m_pin = 0;
                else if (m_sel == 2'b11) m_pin = 1;
            end
            if (t_hit || t_cap) m_flag = 1;
            else if (t_cwr && m_arm && !bus_wdata[7]) m_flag = 0;
            if (t_cwr) m_arm = 0;
            else if (t_crd && m_flag) m_arm = 1;
            if (t_cwr) begin
                m_ghi = 0; m_glo = 0;
                m_ie = bus_wdata[6]; m_mode = bus_wdata[5:4]; m_sel = bus_wdata[3:2];
            end else begin
                m_ghi = (m_ghi && !t_cmt) || (t_vwr && t_oc && bus_addr == 2'd1);
                m_glo = (m_glo && !t_cmt) || (t_vwr && t_oc && bus_addr == 2'd2);
            end
            if (t_vwr && bus_addr == 2'd1) m_hhi = bus_wdata;
            if (t_vwr && bus_addr == 2'd2) m_hlo = bus_wdata;
            m_pinq = pin_in;
        end
    end

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return {m_flag, m_ie, m_mode, m_sel, 2'b00};
            2'd1: return m_val[15:8];
            2'd2: return m_val[7:0];
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk(cur_req, "pin_out", pin_out, m_pin);
            chk(cur_req, "irq", irq, m_flag & m_ie);
            chk(cur_req, "rdata", bus_rdata, exp_rd(bus_addr));
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
            tick = (ph == 0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic peek16(output logic [15:0] v);
        logic [7:0] h, l;
        peek(2'd1, h);
        peek(2'd2, l);
        v = {h, l};
    endtask

    task automatic wait_cnt(logic [15:0] t);
        while (cnt != t) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  v8;
        logic [15:0] v16, t, t2, capt;
        logic        p;
        idle(3);
        @(negedge clk) rst = 0;

        cur_req = "R1";
        peek(2'd0, v8);  chk("R1", "ctrl after reset", v8, 8'h00);
        peek16(v16);     chk("R1", "value after reset", v16, 16'h0000);
        chk("R1", "pin_out after reset", pin_out, 1'b0);
        chk("R1", "irq after reset", irq, 1'b0);

        cur_req = "R10";
        wr(2'd0, 8'h6F);
        peek(2'd0, v8);  chk("R10", "ctrl readback", v8, 8'h6C);
        peek(2'd3, v8);  chk("R10", "unused address", v8, 8'h00);

        cur_req = "R2";
        t = cnt + 16'h0123;
        wr(2'd1, t[15:8]);
        peek16(v16);     chk("R2", "value after one byte", v16, 16'h0000);
        cur_req = "R3";
        wr(2'd2, t[7:0]);
        idle(2);
        peek16(v16);     chk("R3", "value after both bytes", v16, t);
        cur_req = "R5";
        wait_cnt(t + 16'd3);
        chk("R5", "pin set on match", pin_out, 1'b1);
        cur_req = "R7";
        chk("R7", "irq with flag and enable", irq, 1'b1);

        cur_req = "R8";
        wr(2'd0, 8'h6C);
        chk("R8", "unarmed clear keeps irq", irq, 1'b1);
        rd(2'd0);
        wr(2'd0, 8'h64);
        idle(1);
        chk("R8", "armed clear drops irq", irq, 1'b0);

        cur_req = "R5";
        t2 = cnt + 16'h0080;
        wr(2'd2, t2[7:0]);
        wr(2'd1, t2[15:8]);
        wait_cnt(t2 + 16'd3);
        chk("R5", "pin toggled on match", pin_out, 1'b0);
        rd(2'd0);
        wr(2'd0, 8'h28);

        cur_req = "R4";
        t = cnt + 16'h0100;
        wr(2'd1, 8'hEE);
        wr(2'd0, 8'h2C);
        wr(2'd2, t[7:0]);
        idle(4);
        peek16(v16);     chk("R4", "partial write discarded", v16, t2);
        cur_req = "R3";
        wr(2'd1, t[15:8]);
        idle(3);
        peek16(v16);     chk("R3", "low then high commit", v16, t);
        cur_req = "R5";
        wait_cnt(t + 16'd3);
        chk("R5", "pin set on match", pin_out, 1'b1);
        peek(2'd0, v8);  chk("R5", "flag after match", v8[7], 1'b1);
        cur_req = "R7";
        chk("R7", "irq masked by enable", irq, 1'b0);

        cur_req = "R3";
        tick_div = 6;
        wr(2'd2, 8'h34);
        wr(2'd1, 8'h12);
        idle(12);
        peek16(v16);     chk("R3", "commit with slow tick", v16, 16'h1234);
        tick_div = 1;

        cur_req = "R9";
        rd(2'd0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hAB);
        peek(2'd1, v8);  chk("R9", "direct write in idle mode", v8, 8'hAB);
        peek(2'd0, v8);  chk("R8", "armed write cleared flag", v8[7], 1'b0);

        cur_req = "R6";
        wr(2'd0, 8'h14);
        idle(2);
        @(negedge clk); pin_in = 1; capt = cnt;
        idle(2);
        peek16(v16);     chk("R6", "rising capture", v16, capt);
        peek(2'd0, v8);  chk("R6", "flag on capture", v8[7], 1'b1);
        @(negedge clk); pin_in = 0;
        idle(3);
        peek16(v16);     chk("R6", "falling ignored in rising mode", v16, capt);
        wr(2'd0, 8'h18);
        @(negedge clk); pin_in = 1;
        idle(3);
        @(negedge clk); pin_in = 0; capt = cnt;
        idle(2);
        peek16(v16);     chk("R6", "falling capture", v16, capt);
        wr(2'd0, 8'h10);
        @(negedge clk); pin_in = 1;
        idle(3);
        peek16(v16);     chk("R6", "no edge selected", v16, capt);
        wr(2'd0, 8'h1C);
        @(negedge clk); pin_in = 0; capt = cnt;
        idle(2);
        peek16(v16);     chk("R6", "either edge capture", v16, capt);

        cur_req = "R5";
        rd(2'd0);
        wr(2'd0, 8'h20);
        p = pin_out;
        t = cnt + 16'h0040;
        wr(2'd1, t[15:8]);
        wr(2'd2, t[7:0]);
        wait_cnt(t + 16'd3);
        chk("R5", "keep action leaves pin", pin_out, p);
        peek(2'd0, v8);  chk("R5", "flag with keep action", v8[7], 1'b1);

        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule